// File: doc/BRIEF.md
# PHY power-up and DLL lock sequencer

This block is a hardware sequencer that takes a storage-interface PHY from power-down to a locked delay-locked loop, with no software stepping through the sequence. A requester gives one pulse carrying an enable or disable flag, a PHY index and the measured interface clock rate in hertz. The sequencer then issues an ordered series of single-cycle masked writes to the PHY control words. Between the writes it waits fixed times, which it counts in system clock cycles. At set points it samples the calibration-done and DLL-ready status bits.

A disable request powers the PHY down and ends at once. An enable request first sets the drive type and the output tap delay, then powers down and back up, and then checks calibration. After that it programs the DLL frequency band from the clock rate, enables the DLL and checks that the DLL has locked. The last step is skipped when the rate is unknown. Every write carries a 16-bit field mask in its upper half and the new field values in its lower half, so that a write changes only the bits it names. The result comes back as a one-cycle done pulse with a 2-bit error code.

Wait times are parameters in microseconds. They scale with the system clock frequency, which is also a parameter. The DLL wait defaults to a conservative 50 ms, and a simulation can shorten it.

Top module: `dll_bringup_seq`

## Requirements
- R1: A request whose PHY index is not 0 makes no write. The done pulse comes in the first cycle after acceptance, which is the same cycle in which busy first reads high, with error code 1.
- R2: An enable request issues three writes in consecutive cycles, starting in the first busy cycle. They are: power word (wr_sel=1) data 0x00700000, which sets the drive type in bits 6:4 to 0; timing word (wr_sel=0) data 0x0F800A00, which sets tap enable bit 11 and tap select bits 10:7 to 4; power word data 0x00030000, which clears DLL enable bit 1 and power-down-bar bit 0.
- R3: A disable request with index 0 issues only the power word write 0x00030000, in the first busy cycle. Done with error code 0 follows in the next cycle.
- R4: After the power-down write, the power-up write (power word 0x00010001) comes PD+1 cycles later, where PD = SYS_CLK_MHZ×PWR_SETTLE_US. Calibration done is sampled in the cycle CAL = SYS_CLK_MHZ×CAL_WAIT_US cycles after the power-up write. If it is low, done follows in the next cycle with error code 2 and no further write.
- R5: The frequency band code is 0 for a rate of 0, 1 below 75 MHz, 2 below 125 MHz, 3 below 175 MHz, and 0 at 175 MHz or above.
- R6: When calibration passes, the timing word write with data {16'h3000, band code in bits 13:12} comes CAL+1 cycles after the power-up write. The power word write 0x00020002 (DLL enable) comes in the next cycle.
- R7: With a nonzero rate, DLL ready is sampled DLLW = SYS_CLK_MHZ×DLL_WAIT_US cycles after the DLL enable write, and done follows one cycle later. The error code is 0 if ready was high and 3 if it was low.
- R8: With a rate of 0, done with error code 0 comes in the cycle after the DLL enable write, and DLL ready is not checked.
- R9: Every write has its value bits (15:0) inside its mask bits (31:16).
- R10: Busy is high from the cycle after acceptance through the done cycle and low afterwards. Done lasts one cycle.
- R11: A request is accepted only while busy is low. A request raised during a sequence, or in its done cycle, changes no write and no result and starts no new sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request pulse, taken only while idle |
| req_enable | input | 1 | 1 = power up and lock, 0 = power down |
| req_phy_idx | input | IDX_W | PHY index; only 0 is valid |
| req_clk_rate_hz | input | RATE_W | Measured interface clock rate in Hz, 0 = unknown |
| stat_cal_done | input | 1 | PHY calibration-done status bit |
| stat_dll_ready | input | 1 | PHY DLL-ready status bit |
| wr_valid | output | 1 | Write strobe, one cycle per write |
| wr_sel | output | 1 | Target word: 0 timing word, 1 power word |
| wr_data | output | 32 | {field mask, field values} |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| err_code | output | 2 | 0 ok, 1 bad index, 2 calibration fail, 3 lock fail |

## Verification
The done pulse of one sequence and the acceptance of the next request are the two functions that can meet in one cycle. A request held in the done cycle must be dropped, because the sequencer is still busy. The bench raises a request exactly in the cycle where it sees done high. It then judges that busy stays low and that no write appears in the cycles after. A second probe raises a request in the middle of a timed wait and compares the whole write log and the result against the undisturbed sequence.

// File: rtl/dbs_pkg.sv
package dbs_pkg;

  typedef enum logic [2:0] {
    OP_NONE, OP_DRV, OP_OTAP, OP_PDN, OP_PUP, OP_FSEL, OP_DLLEN
  } wr_op_e;

  localparam logic [1:0] ERR_OK   = 2'd0;
  localparam logic [1:0] ERR_IDX  = 2'd1;
  localparam logic [1:0] ERR_CAL  = 2'd2;
  localparam logic [1:0] ERR_LOCK = 2'd3;

  localparam logic SEL_TIMING = 1'b0;
  localparam logic SEL_POWER  = 1'b1;

  // field masks (bit positions are decoded by the PHY control words)
  localparam logic [15:0] M_DRVTYPE = 16'h0070;
  localparam logic [15:0] M_TAPOUT  = 16'h0F80;
  localparam logic [15:0] M_FBAND   = 16'h3000;
  localparam logic [15:0] M_DLLON   = 16'h0002;
  localparam logic [15:0] M_PWRUP   = 16'h0001;
  localparam logic [3:0]  TAP_SEL_VAL = 4'd4;

  localparam logic [63:0] LIM_LO  = 64'd75_000_000;
  localparam logic [63:0] LIM_MID = 64'd125_000_000;
  localparam logic [63:0] LIM_HI  = 64'd175_000_000;

  function automatic logic [1:0] band_code(input logic [63:0] rate);
    if (rate == 64'd0)        return 2'd0;
    else if (rate < LIM_LO)   return 2'd1;
    else if (rate < LIM_MID)  return 2'd2;
    else if (rate < LIM_HI)   return 2'd3;
    else                      return 2'd0;
  endfunction

  function automatic logic [31:0] pack_wr(input logic [15:0] mask, input logic [15:0] val);
    return {mask, val & mask};
  endfunction

endpackage

// File: rtl/dbs_timer.sv
module dbs_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);

  AST_TMR_REST: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && zero) |=> zero); // R4
endmodule

// File: rtl/dbs_band.sv
module dbs_band #(
  parameter int RATE_W = 32
) (
  input  logic [RATE_W-1:0] rate,
  output logic [1:0]        code,
  output logic              rate_unknown
);
  import dbs_pkg::*;
  assign code         = band_code(64'(rate));
  assign rate_unknown = (rate == '0);
endmodule

// File: rtl/dbs_wr_fmt.sv
module dbs_wr_fmt (
  input  dbs_pkg::wr_op_e op,
  input  logic [1:0]      band,
  output logic            valid,
  output logic            sel,
  output logic [31:0]     data
);
  import dbs_pkg::*;

  always_comb begin
    valid = 1'b1;
    sel   = SEL_POWER;
    data  = '0;
    unique case (op)
      OP_DRV:   data = pack_wr(M_DRVTYPE, 16'h0000);
      OP_OTAP: begin
        sel  = SEL_TIMING;
        data = pack_wr(M_TAPOUT, {4'b0000, 1'b1, TAP_SEL_VAL, 7'b0});
      end
      OP_PDN:   data = pack_wr(M_DLLON | M_PWRUP, 16'h0000);
      OP_PUP:   data = pack_wr(M_PWRUP, M_PWRUP);
      OP_FSEL: begin
        sel  = SEL_TIMING;
        data = pack_wr(M_FBAND, {2'b00, band, 12'h000});
      end
      OP_DLLEN: data = pack_wr(M_DLLON, M_DLLON);
      default:  valid = 1'b0;
    endcase
  end
endmodule

// File: rtl/dll_bringup_seq.sv
module dll_bringup_seq #(
  parameter int SYS_CLK_MHZ    = 100,
  parameter int PWR_SETTLE_US  = 3,
  parameter int CAL_WAIT_US    = 10,
  parameter int DLL_WAIT_US    = 50000,
  parameter int IDX_W          = 2,
  parameter int RATE_W         = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_enable,
  input  logic [IDX_W-1:0]  req_phy_idx,
  input  logic [RATE_W-1:0] req_clk_rate_hz,
  input  logic              stat_cal_done,
  input  logic              stat_dll_ready,
  output logic              wr_valid,
  output logic              wr_sel,
  output logic [31:0]       wr_data,
  output logic              busy,
  output logic              done,
  output logic [1:0]        err_code
);
  import dbs_pkg::*;

  localparam int PD_CYC  = SYS_CLK_MHZ * PWR_SETTLE_US;
  localparam int CAL_CYC = SYS_CLK_MHZ * CAL_WAIT_US;
  localparam int DLL_CYC = SYS_CLK_MHZ * DLL_WAIT_US;
  localparam int MAX_A   = (PD_CYC > CAL_CYC) ? PD_CYC : CAL_CYC;
  localparam int MAX_CYC = (MAX_A > DLL_CYC) ? MAX_A : DLL_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_DRV, S_OTAP, S_PDN, S_WPD, S_PUP, S_WCAL,
    S_FSEL, S_DLLEN, S_WDLL, S_DONE
  } st_e;

  st_e               st_q, st_d;
  logic              en_q;
  logic [RATE_W-1:0] rate_q;
  logic [1:0]        err_q, err_d;
  logic              tmr_load, tmr_zero;
  logic [CNT_W-1:0]  tmr_val;
  logic [1:0]        band;
  logic              rate_unknown;
  wr_op_e            wr_op;
  logic              accept;

  assign accept = (st_q == S_IDLE) && req_valid;

  dbs_band #(.RATE_W(RATE_W)) i_band (
    .rate(rate_q), .code(band), .rate_unknown(rate_unknown)
  );

  dbs_timer #(.CNT_W(CNT_W)) i_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero)
  );

  dbs_wr_fmt i_fmt (
    .op(wr_op), .band(band), .valid(wr_valid), .sel(wr_sel), .data(wr_data)
  );

  always_comb begin
    st_d     = st_q;
    err_d    = err_q;
    wr_op    = OP_NONE;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (st_q)
      S_IDLE: if (req_valid) begin
        if (req_phy_idx != '0) begin
          st_d  = S_DONE;
          err_d = ERR_IDX;
        end else begin
          st_d  = req_enable ? S_DRV : S_PDN;
          err_d = ERR_OK;
        end
      end
      S_DRV:  begin wr_op = OP_DRV;  st_d = S_OTAP; end
      S_OTAP: begin wr_op = OP_OTAP; st_d = S_PDN;  end
      S_PDN: begin
        wr_op = OP_PDN;
        if (en_q) begin
          st_d     = S_WPD;
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(PD_CYC - 1);
        end else begin
          st_d = S_DONE;
        end
      end
      S_WPD: if (tmr_zero) st_d = S_PUP;
      S_PUP: begin
        wr_op    = OP_PUP;
        st_d     = S_WCAL;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(CAL_CYC - 1);
      end
      S_WCAL: if (tmr_zero) begin
        if (stat_cal_done) st_d = S_FSEL;
        else begin
          st_d  = S_DONE;
          err_d = ERR_CAL;
        end
      end
      S_FSEL: begin wr_op = OP_FSEL; st_d = S_DLLEN; end
      S_DLLEN: begin
        wr_op = OP_DLLEN;
        if (rate_unknown) st_d = S_DONE;
        else begin
          st_d     = S_WDLL;
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(DLL_CYC - 1);
        end
      end
      S_WDLL: if (tmr_zero) begin
        st_d  = S_DONE;
        err_d = stat_dll_ready ? ERR_OK : ERR_LOCK;
      end
      S_DONE: st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      en_q   <= 1'b0;
      rate_q <= '0;
      err_q  <= ERR_OK;
    end else begin
      st_q  <= st_d;
      err_q <= err_d;
      if (accept) begin
        en_q   <= req_enable;
        rate_q <= req_clk_rate_hz;
      end
    end
  end

  assign busy     = (st_q != S_IDLE);
  assign done     = (st_q == S_DONE);
  assign err_code = err_q;

  AST_IDX_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err_code == ERR_IDX) |-> !$past(busy)); // R1
  AST_CAL_SAMPLED: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err_code == ERR_CAL) |-> !$past(stat_cal_done)); // R4
  AST_FSEL_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_op == OP_DLLEN) |-> $past(wr_op == OP_FSEL)); // R6
  AST_LOCK_SAMPLED: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err_code == ERR_LOCK) |-> !$past(stat_dll_ready)); // R7
  AST_VAL_IN_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> ((wr_data[15:0] & ~wr_data[31:16]) == 16'h0)); // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10
  AST_BUSY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy); // R10
  AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !wr_valid); // R11
endmodule

// File: tb/test_dll_bringup_seq.sv
module test_dll_bringup_seq;
  localparam int CLK_PERIOD = 10;
  localparam int SYS_MHZ = 2;
  localparam int DLL_US  = 5;
  localparam int PD   = SYS_MHZ * 3;
  localparam int CAL  = SYS_MHZ * 10;
  localparam int DLLW = SYS_MHZ * DLL_US;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_enable = 1'b0;
  logic [1:0] req_phy_idx = '0;
  logic [31:0] req_clk_rate_hz = '0;
  logic stat_cal_done = 1'b0, stat_dll_ready = 1'b0;
  logic wr_valid, wr_sel, busy, done;
  logic [31:0] wr_data;
  logic [1:0] err_code;

  dll_bringup_seq #(.SYS_CLK_MHZ(SYS_MHZ), .DLL_WAIT_US(DLL_US)) i_dll_bringup_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_enable(req_enable),
    .req_phy_idx(req_phy_idx), .req_clk_rate_hz(req_clk_rate_hz),
    .stat_cal_done(stat_cal_done), .stat_dll_ready(stat_dll_ready),
    .wr_valid(wr_valid), .wr_sel(wr_sel), .wr_data(wr_data),
    .busy(busy), .done(done), .err_code(err_code));

  always #(CLK_PERIOD/2) clk = ~clk;

  int errors = 0, checks = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // monitor, sampled away from the active edge
  int n_wr, n_done, busy_start, done_cyc, extra_busy;
  logic [1:0] done_err;
  logic log_sel [16];
  logic [31:0] log_data [16];
  int log_cyc [16];
  logic busy_prev = 1'b0;
  always @(negedge clk) begin
    if (wr_valid && n_wr < 16) begin
      log_sel[n_wr] = wr_sel; log_data[n_wr] = wr_data; log_cyc[n_wr] = cyc; n_wr++;
    end
    if (busy && !busy_prev && busy_start < 0) busy_start = cyc;
    if (done) begin n_done++; done_cyc = cyc; done_err = err_code; end
    else if (n_done > 0 && busy) extra_busy++;
    busy_prev = busy;
  end

  task automatic chk(input string rq, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", rq, what, act, exp);
    end
  endtask

  initial begin : watchdog
    wait (cyc > 150000);
    errors++;
    $display("FAIL watchdog: actual=%0d cycles expected<150000", cyc);
    $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  // bench's own band rule: count thresholds reached, rotate by one
  function automatic int exp_band(input longint rate);
    longint lim [3] = '{75_000_000, 125_000_000, 175_000_000};
    int n = 0;
    if (rate == 0) return 0;
    foreach (lim[i]) if (rate >= lim[i]) n++;
    return (n + 1) % 4;
  endfunction

  int ne;
  logic e_sel [16];
  logic [31:0] e_data [16];
  int e_gap [16];
  task automatic push(input logic s, input logic [31:0] d, input int g);
    e_sel[ne] = s; e_data[ne] = d; e_gap[ne] = g; ne++;
  endtask

  task automatic run(input logic en, input logic [1:0] idx, input longint rate,
                     input logic cal, input logic dll, input int intr, input logic at_done);
    int done_gap, exp_err, ref_cyc;
    ne = 0;
    @(negedge clk);
    n_wr = 0; n_done = 0; busy_start = -1; extra_busy = 0;
    stat_cal_done = cal; stat_dll_ready = dll;
    req_valid = 1'b1; req_enable = en; req_phy_idx = idx; req_clk_rate_hz = 32'(rate);
    @(negedge clk);
    req_valid = 1'b0;
    for (int k = 0; k < 3000; k++) begin
      if (done) break;
      if (k == intr) begin req_valid = 1'b1; req_enable = 1'b0; req_phy_idx = 2'd0; end
      @(negedge clk);
      req_valid = 1'b0;
    end
    if (at_done && done) begin
      req_valid = 1'b1; req_enable = 1'b1; req_phy_idx = 2'd0;
      @(negedge clk);
      req_valid = 1'b0;
    end
    repeat (4) @(negedge clk);
    // expected sequence
    exp_err = 0; done_gap = 0;
    if (idx != 0) begin
      exp_err = 1; done_gap = 0;
    end else if (!en) begin
      push(1'b1, 32'h00030000, 0); done_gap = 1;
    end else begin
      push(1'b1, 32'h00700000, 0);
      push(1'b0, 32'h0F800A00, 1);
      push(1'b1, 32'h00030000, 1);
      push(1'b1, 32'h00010001, PD + 1);
      if (!cal) begin
        exp_err = 2; done_gap = CAL + 1;
      end else begin
        push(1'b0, 32'h30000000 | (32'(exp_band(rate)) << 12), CAL + 1);
        push(1'b1, 32'h00020002, 1);
        if (rate == 0) done_gap = 1;
        else begin done_gap = DLLW + 1; exp_err = dll ? 0 : 3; end
      end
    end
    chk("R10", "done count", n_done, 1);
    chk("R2", "write count", n_wr, ne);
    ref_cyc = busy_start;
    for (int i = 0; i < ne && i < n_wr; i++) begin
      chk("R9", "write sel", log_sel[i], e_sel[i]);
      chk(i == 4 ? "R6" : "R2", "write data", log_data[i], e_data[i]);
      chk(i == 3 ? "R4" : "R6", "write gap", log_cyc[i] - ref_cyc, e_gap[i]);
      ref_cyc = log_cyc[i];
    end
    chk(exp_err == 3 ? "R7" : (rate == 0 ? "R8" : "R1"), "done gap", done_cyc - ref_cyc, done_gap);
    chk(exp_err == 2 ? "R4" : "R7", "error code", done_err, exp_err);
    chk("R11", "busy after done", extra_busy, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R10", "reset busy", busy, 0);
    chk("R10", "reset done", done, 0);
    chk("R11", "reset wr_valid", wr_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R5 sweep across band edges, R7 lock pass
    begin
      longint rates [10] = '{1, 74_999_999, 75_000_000, 100_000_000, 124_999_999,
                             125_000_000, 174_999_999, 175_000_000, 200_000_000, 64'hFFFF_FFFF};
      foreach (rates[i]) run(1'b1, 2'd0, rates[i], 1'b1, 1'b1, -1, 1'b0);
    end
    run(1'b1, 2'd0, 0, 1'b1, 1'b0, -1, 1'b0);          // R8 rate unknown, ready ignored
    run(1'b1, 2'd0, 50_000_000, 1'b0, 1'b1, -1, 1'b0); // R4 calibration fail
    run(1'b1, 2'd0, 150_000_000, 1'b1, 1'b0, -1, 1'b0);// R7 lock fail
    run(1'b0, 2'd0, 100_000_000, 1'b1, 1'b1, -1, 1'b0);// R3 disable
    for (int ix = 1; ix < 4; ix++) begin
      run(1'b1, 2'(ix), 100_000_000, 1'b1, 1'b1, -1, 1'b0); // R1
      run(1'b0, 2'(ix), 0, 1'b1, 1'b1, -1, 1'b0);           // R1
    end
    run(1'b1, 2'd0, 100_000_000, 1'b1, 1'b1, 5, 1'b0);   // R11 request mid-wait
    run(1'b1, 2'd0, 100_000_000, 1'b1, 1'b1, 30, 1'b1);  // R11 request in done cycle
    run(1'b0, 2'd0, 0, 1'b1, 1'b1, -1, 1'b1);            // R11 done-cycle request, short path
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule